// File: doc/BRIEF.md
# I2C Command-Driven Bus Master

This block is a byte-level I2C bus master controlled through three write-only registers. Software loads a target register with the 7-bit target address and a direction bit, and a transmit register with the outgoing byte. A write to the command register then starts one operation. The operation runs an optional START or repeated START, the address byte and its acknowledge slot, one data byte and its acknowledge slot, and an optional STOP.

Because every operation is a single byte, software builds a longer transfer from a chain of commands. It can keep the bus between commands, switch to another target with a repeated START, and choose per byte whether a received byte gets an acknowledge.

The block pulls the bus lines low through output-enable pins and reads their actual levels back through input pins. It reports completion with an interrupt level, a busy flag and a not-acknowledge error flag. In receive direction the received byte is presented on `rx_byte`. The bit rate is fixed at elaboration: one SCL period is four quarter-periods of `QTR_CYCLES` system clocks.

Top module: `i2c_cmd_master`

## Requirements
- R1: Target register (`reg_sel`=0) holds the address in bits [7:1] and the direction in bit 0. After a START the block shifts out these eight bits, most significant first, followed by an acknowledge slot.
- R2: Direction 0 sends the transmit register (`reg_sel`=1) as the data byte. Direction 1 shifts in one byte from the target, and that byte appears on `rx_byte` by the time `irq` rises.
- R3: Command register (`reg_sel`=2) fields are RUN=bit0, START=bit1, STOP=bit2 and ACK=bit3. A command with RUN, START and STOP set produces START, address byte, data byte and STOP, then leaves both lines released.
- R4: With STOP=0 the block keeps the bus with SCL pulled low. From there, a command with START=1 produces a repeated START with no STOP in between. A command with RUN=1 and START=0 transfers only a data byte in the latched direction.
- R5: When receiving, ACK=1 pulls SDA low in the acknowledge slot after the data byte. ACK=0 leaves SDA released in that slot, which is a not-acknowledge.
- R6: When an operation ends, normally or by abort, `irq` goes to 1 and `busy` goes to 0. `irq` returns to 0 when the next command is accepted, and `irq` and `busy` are never both 1.
- R7: A released SDA in the acknowledge slot of the address byte or of a transmitted data byte sets `nack_err`. The operation is then aborted with a STOP. `nack_err` is cleared by the next accepted command.
- R8: `busy` is 1 from the cycle after a command is accepted until the operation ends. A command write is ignored while `busy` is 1, when RUN=0, and when START=0 while the bus is not held.
- R9: SCL rising edges inside a byte are 4*`QTR_CYCLES` clocks apart. SDA changes only while SCL is low, except for the START and STOP edges.
- R10: Lines are open drain: a 1 on `scl_oe`/`sda_oe` pulls the line low. When idle, both enables are 0. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R11: After reset `busy`, `irq`, `nack_err`, `scl_oe` and `sda_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 target, 1 transmit, 2 command |
| reg_wdata | input | 8 | Register write data |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_byte | output | 8 | Last byte received from the target |
| busy | output | 1 | Operation in progress |
| irq | output | 1 | Operation ended (completion or abort) |
| nack_err | output | 1 | Last operation aborted on a not-acknowledge |

## Verification
The bench attaches a behavioural target that decodes START and STOP from the line levels, acknowledges only its own address, and can refuse a written byte.

It chains a write and a read through a repeated START and counts START and STOP events. A design that dropped the held bus would add a STOP, and one that mishandled the line release would add a spurious START.

It reads two bytes with ACK set and then cleared. A swapped acknowledge polarity shows up in the target's record of the master's acknowledge, and a wrong shift order shows up as a bit-reversed `rx_byte`.

It also sends an unmatched address, a refused data byte, an idle data-only command and a command written while busy. A design that ignored a not-acknowledge, started a data-only command on an idle bus, or re-triggered while busy would show a wrong error flag, a missing STOP, or an extra byte at the target.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BITS,
    S_STOP,
    S_HOLD
  } seq_state_t;

  // Command word fields: bit3 ack, bit2 stop, bit1 start, bit0 run
  typedef struct packed {
    logic ack;
    logic stop;
    logic start;
    logic run;
  } ctrl_cmd_t;

  localparam logic [1:0] SEL_TARGET = 2'd0;
  localparam logic [1:0] SEL_TXDATA = 2'd1;
  localparam logic [1:0] SEL_CMD    = 2'd2;

  function automatic ctrl_cmd_t decode_cmd(input logic [7:0] w);
    return ctrl_cmd_t'(w[3:0]);
  endfunction

  // Pull-down request for one bit cell: drive a 0 when sending,
  // release when listening; in the acknowledge slot the roles swap.
  function automatic logic cell_pull(input logic sending, input logic ack_slot,
                                     input logic bit_val, input logic ack_en);
    if (ack_slot) return sending ? 1'b0 : ack_en;
    return sending ? ~bit_val : 1'b0;
  endfunction

endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int QTR_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(QTR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart || cnt == LAST) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !restart;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic         msb,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (load)  value <= load_val;
    else if (shift) value <= {value[W-2:0], sin};
  end

  assign msb = value[W-1];
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int QTR_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       irq,
  output logic       nack_err
);
  localparam int          BYTE_W   = 8;
  localparam logic [3:0]  ACK_SLOT = 4'(BYTE_W);

  seq_state_t  state;
  logic [1:0]  q;
  logic [3:0]  bit_idx;
  logic        in_data, cur_dir, cmd_ack, cmd_stop, rs_flag;
  logic        ack_line, sda_drv;
  logic [7:0]  target_reg, tx_reg;
  ctrl_cmd_t   cmd_w;
  logic        tick, sh_load, sh_shift, sh_msb;
  logic [7:0]  sh_value, sh_load_val;

  // Named events for the checker
  logic ev_accept, ev_step, ev_nack, ev_done, bus_held, in_bit_cell, tx_mode, at_ack;

  assign cmd_w       = decode_cmd(reg_wdata);
  assign busy        = (state == S_START) || (state == S_BITS) || (state == S_STOP);
  assign bus_held    = (state == S_HOLD);
  assign in_bit_cell = (state == S_BITS);
  assign tx_mode     = !in_data || !cur_dir;
  assign at_ack      = (bit_idx == ACK_SLOT);
  assign ev_accept   = reg_we && (reg_sel == SEL_CMD) && cmd_w.run && !busy
                       && (cmd_w.start || bus_held);
  assign ev_step     = tick && busy && (q == 2'd3);
  assign ev_nack     = ev_step && in_bit_cell && at_ack && tx_mode && ack_line;
  assign ev_done     = ev_step && ((state == S_STOP) ||
                       (in_bit_cell && at_ack && in_data && !ev_nack && !cmd_stop));

  assign sh_load     = ev_accept || (ev_step && in_bit_cell && at_ack && !in_data && !ev_nack);
  assign sh_load_val = (ev_accept && cmd_w.start) ? target_reg : tx_reg;
  assign sh_shift    = tick && in_bit_cell && (q == 2'd2) && !at_ack;

  i2c_qtr_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(ev_accept), .tick(tick)
  );

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_load_val),
    .shift(sh_shift), .sin(sda_i), .msb(sh_msb), .value(sh_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_reg <= '0;
      tx_reg     <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_TARGET) target_reg <= reg_wdata;
      if (reg_sel == SEL_TXDATA) tx_reg     <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      q        <= '0;
      bit_idx  <= '0;
      in_data  <= 1'b0;
      cur_dir  <= 1'b0;
      cmd_ack  <= 1'b0;
      cmd_stop <= 1'b0;
      rs_flag  <= 1'b0;
      ack_line <= 1'b1;
      sda_drv  <= 1'b0;
      irq      <= 1'b0;
      nack_err <= 1'b0;
      rx_byte  <= '0;
    end else if (ev_accept) begin
      state    <= cmd_w.start ? S_START : S_BITS;
      q        <= '0;
      bit_idx  <= '0;
      in_data  <= !cmd_w.start;
      cmd_ack  <= cmd_w.ack;
      cmd_stop <= cmd_w.stop;
      rs_flag  <= bus_held;
      irq      <= 1'b0;
      nack_err <= 1'b0;
      if (cmd_w.start) begin
        cur_dir <= target_reg[0];
        sda_drv <= 1'b0;
      end
    end else if (tick && busy) begin
      q <= q + 2'd1;
      case (state)
        S_START: if (q == 2'd1) sda_drv <= 1'b1;
        S_STOP: begin
          if (q == 2'd0) sda_drv <= 1'b1;
          if (q == 2'd2) sda_drv <= 1'b0;
        end
        S_BITS: begin
          if (q == 2'd0) sda_drv  <= cell_pull(tx_mode, at_ack, sh_msb, cmd_ack);
          if (q == 2'd2) ack_line <= sda_i;
        end
        default: ;
      endcase
      if (q == 2'd3) begin
        case (state)
          S_START: begin
            state   <= S_BITS;
            bit_idx <= '0;
          end
          S_STOP: begin
            state <= S_IDLE;
            irq   <= 1'b1;
          end
          S_BITS: begin
            if (!at_ack) begin
              bit_idx <= bit_idx + 4'd1;
            end else if (ev_nack) begin
              state    <= S_STOP;
              nack_err <= 1'b1;
            end else if (!in_data) begin
              in_data <= 1'b1;
              bit_idx <= '0;
            end else begin
              if (cur_dir) rx_byte <= sh_value;
              if (cmd_stop) state <= S_STOP;
              else begin
                state <= S_HOLD;
                irq   <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_START: scl_oe = ((q == 2'd0) && rs_flag) || (q == 2'd3);
      S_BITS:  scl_oe = (q < 2'd2);
      S_STOP:  scl_oe = (q < 2'd2);
      S_HOLD:  scl_oe = 1'b1;
      default: scl_oe = 1'b0;
    endcase
  end

  assign sda_oe = sda_drv;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic irq,
  input logic nack_err,
  input logic scl_oe,
  input logic sda_oe,
  input logic ev_accept,
  input logic ev_done,
  input logic ev_nack,
  input logic in_bit_cell,
  input logic bus_held
);
  assert_hold_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_held |-> scl_oe);

  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (irq && !busy));

  assert_irq_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && busy));

  assert_nack_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> (nack_err && busy));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  assert_sda_still_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit_cell && !scl_oe && $past(in_bit_cell) && !$past(scl_oe)) |-> $stable(sda_oe));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_held) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .nack_err(nack_err),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .ev_accept(ev_accept), .ev_done(ev_done),
  .ev_nack(ev_nack), .in_bit_cell(in_bit_cell), .bus_held(bus_held)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam int QTR = 4;
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic scl_i, sda_i, scl_oe, sda_oe, busy, irq, nack_err;
  logic [7:0] rx_byte;

  always #2.5ns clk = ~clk;

  // Open-drain bus with target pull-down
  logic slv_pull = 1'b0;
  assign scl_i = ~scl_oe;
  assign sda_i = ~(sda_oe | slv_pull);

  i2c_cmd_master #(.QTR_CYCLES(QTR)) i_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .busy(busy), .irq(irq), .nack_err(nack_err)
  );

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard queues ----------------
  typedef struct {
    bit         err;
    bit         chk_rx;
    logic [7:0] rx;
    bit         held;
  } done_t;
  done_t      exp_done[$];
  logic [7:0] exp_wr[$];
  logic [7:0] rd_q[$];

  // ---------------- behavioural target ----------------
  int   cnt = 0, n_start = 0, n_stop = 0, n_wr = 0;
  logic active = 1'b0, first = 1'b0, addressed = 1'b0, rd_mode = 1'b0, sending = 1'b0;
  logic nack_data = 1'b0, last_mack = 1'b1;
  logic [7:0] sh = '0, rd_byte = '0, last_addr = '0;

  task automatic wr_seen(input logic [7:0] b);
    n_wr++;
    if (exp_wr.size() == 0) check(1'b0, "R2", "unexpected write byte", b, 0);
    else begin
      logic [7:0] e;
      e = exp_wr.pop_front();
      check(b == e, "R2", "byte at target", b, e);
    end
  endtask

  always @(negedge sda_i) if (scl_i === 1'b1 && rst_n) begin
    n_start++; active = 1'b1; cnt = 0; first = 1'b1;
    addressed = 1'b0; sending = 1'b0; slv_pull = 1'b0;
  end
  always @(posedge sda_i) if (scl_i === 1'b1 && active) begin
    n_stop++; active = 1'b0; addressed = 1'b0; sending = 1'b0; slv_pull = 1'b0;
  end
  always @(posedge scl_i) if (active) begin
    if (cnt < 8) begin sh = {sh[6:0], sda_i}; cnt++; end
    else if (cnt == 8) begin
      if (rd_mode && addressed && !first) begin
        last_mack = sda_i;
        if (sda_i) sending = 1'b0;
      end
      cnt = 9;
    end
  end
  always @(negedge scl_i) if (active) begin
    if (cnt == 8) begin
      if (first) begin
        last_addr = sh;
        addressed = (sh[7:1] == MY_ADDR);
        rd_mode   = sh[0];
        slv_pull  = addressed;
      end else if (addressed && !rd_mode) begin
        wr_seen(sh);
        slv_pull = !nack_data;
      end else slv_pull = 1'b0;
    end else if (cnt == 9) begin
      cnt = 0;
      slv_pull = 1'b0;
      if (first) begin first = 1'b0; sending = addressed && rd_mode; end
      if (sending) begin
        rd_byte  = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hFF;
        slv_pull = ~rd_byte[7];
      end
    end else if (cnt >= 1 && cnt <= 7 && sending) slv_pull = ~rd_byte[7-cnt];
  end

  // ---------------- completion monitor ----------------
  initial forever begin
    @(posedge irq);
    @(negedge clk);
    if (exp_done.size() == 0) check(1'b0, "R8", "unexpected completion", 1, 0);
    else begin
      done_t e;
      e = exp_done.pop_front();
      check(nack_err == e.err, "R7", "error flag at completion", nack_err, e.err);
      check(!busy, "R6", "busy at completion", busy, 0);
      check(scl_oe == e.held, "R4", "SCL held after completion", scl_oe, e.held);
      if (e.chk_rx) check(rx_byte == e.rx, "R2", "received byte", rx_byte, e.rx);
    end
  end

  // ---------------- driver ----------------
  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] ctrl, input bit err, input bit chk_rx,
                        input logic [7:0] rx, input bit held);
    done_t e;
    e.err = err; e.chk_rx = chk_rx; e.rx = rx; e.held = held;
    exp_done.push_back(e);
    wr_reg(2'd2, ctrl);
    wait (irq === 1'b1);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    int s0, p0, w0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset values
    check({busy, irq, nack_err, scl_oe, sda_oe} == 5'b0, "R11", "reset outputs",
          {busy, irq, nack_err, scl_oe, sda_oe}, 0);

    // R1 R3 R9 R10: single complete write, address 3A direction 0
    s0 = n_start; p0 = n_stop;
    wr_reg(2'd0, {MY_ADDR, 1'b0});
    wr_reg(2'd1, 8'h5C);
    exp_wr.push_back(8'h5C);
    fork
      run_op(8'h07, 1'b0, 1'b0, 8'h00, 1'b0);
      begin @(posedge scl_i); t1 = int'(cyc); @(posedge scl_i); t2 = int'(cyc); end
    join
    check(last_addr == {MY_ADDR, 1'b0}, "R1", "address byte on bus", last_addr, {MY_ADDR, 1'b0});
    check(t2 - t1 == 4 * QTR, "R9", "SCL period in clocks", t2 - t1, 4 * QTR);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R3", "START/STOP count",
          (n_start - s0) * 16 + (n_stop - p0), 8'h11);
    check(!scl_oe && !sda_oe, "R10", "lines released when idle", {scl_oe, sda_oe}, 0);

    // R5 R2 R4: two-byte read, acknowledge then not-acknowledge
    p0 = n_stop;
    rd_q.push_back(8'hA5); rd_q.push_back(8'h3C);
    wr_reg(2'd0, {MY_ADDR, 1'b1});
    run_op(8'h0B, 1'b0, 1'b1, 8'hA5, 1'b1);
    check(last_mack == 1'b0, "R5", "master ACK with ACK=1", last_mack, 0);
    check(busy == 1'b0 && scl_oe == 1'b1, "R4", "bus held idle", {busy, scl_oe}, 2'b01);
    run_op(8'h05, 1'b0, 1'b1, 8'h3C, 1'b0);
    check(last_mack == 1'b1, "R5", "master NACK with ACK=0", last_mack, 1);
    check(n_stop - p0 == 1, "R4", "one STOP for chained read", n_stop - p0, 1);

    // R8: data-only on idle bus and RUN=0 ignored
    wr_reg(2'd2, 8'h01);
    repeat (4) @(negedge clk);
    check(!busy && !scl_oe, "R8", "data-only on idle bus", busy, 0);
    wr_reg(2'd2, 8'h06);
    repeat (4) @(negedge clk);
    check(!busy && !scl_oe, "R8", "RUN=0 command", busy, 0);

    // R8: command written while busy is ignored
    w0 = n_wr; p0 = n_stop;
    wr_reg(2'd0, {MY_ADDR, 1'b0});
    wr_reg(2'd1, 8'h11);
    exp_wr.push_back(8'h11);
    exp_done.push_back('{err: 1'b0, chk_rx: 1'b0, rx: 8'h00, held: 1'b0});
    wr_reg(2'd2, 8'h07);
    repeat (10) @(negedge clk);
    check(busy, "R8", "busy during operation", busy, 1);
    wr_reg(2'd2, 8'h07);
    wait (irq === 1'b1);
    repeat (8 * 4 * QTR) @(negedge clk);
    check(!busy && (n_wr - w0) == 1 && (n_stop - p0) == 1, "R8", "bytes after busy rewrite",
          n_wr - w0, 1);

    // R4: write, repeated START, read
    s0 = n_start; p0 = n_stop;
    wr_reg(2'd1, 8'h22);
    exp_wr.push_back(8'h22);
    run_op(8'h03, 1'b0, 1'b0, 8'h00, 1'b1);
    rd_q.push_back(8'h77);
    wr_reg(2'd0, {MY_ADDR, 1'b1});
    run_op(8'h07, 1'b0, 1'b1, 8'h77, 1'b0);
    check(n_start - s0 == 2 && n_stop - p0 == 1, "R4", "repeated START chain",
          (n_start - s0) * 16 + (n_stop - p0), 8'h21);

    // R7: unmatched address aborts with STOP
    w0 = n_wr; p0 = n_stop;
    wr_reg(2'd0, {7'h11, 1'b0});
    run_op(8'h07, 1'b1, 1'b0, 8'h00, 1'b0);
    check(n_stop - p0 == 1 && n_wr == w0, "R7", "STOP after address NACK", n_stop - p0, 1);
    check(!sda_oe && !scl_oe, "R7", "bus released after abort", {scl_oe, sda_oe}, 0);

    // R7: refused data byte
    nack_data = 1'b1;
    wr_reg(2'd0, {MY_ADDR, 1'b0});
    wr_reg(2'd1, 8'h99);
    exp_wr.push_back(8'h99);
    run_op(8'h07, 1'b1, 1'b0, 8'h00, 1'b0);
    nack_data = 1'b0;

    // R6: error cleared by next accepted command
    wr_reg(2'd1, 8'h42);
    exp_wr.push_back(8'h42);
    run_op(8'h07, 1'b0, 1'b0, 8'h00, 1'b0);
    check(irq && !nack_err, "R6", "irq held, error cleared", {irq, nack_err}, 2'b10);

    check(exp_done.size() == 0 && exp_wr.size() == 0, "R2", "scoreboard drained",
          exp_done.size() + exp_wr.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule